// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block puts one complete packet onto a low-speed USB differential pair. A caller raises a request with a payload byte count. The block then takes the pair out of high impedance in the idle J state and sends the synchronization pattern. It follows with the payload bytes, which it pulls one at a time from a byte source through a small fetch handshake. It ends with the end-of-packet signalling and then lets the pair go again.

Every symbol on the wire lasts one bit period. The bit period comes from a clock divider, and the default parameters give 1.5 Mb/s from a 12 MHz clock. Bits go out least significant first. They are NRZI coded, with a stuffed transition after every run of six ones, and the run count carries over from one byte to the next. The caller decides which bytes make up the packet (a handshake PID or a data packet with its CRC already appended). The block only serializes them.

Top module: `lsPacketTx`

## Requirements
- R1: While reset is held and after it is released, `oe`, `done` and `byteReq` are low and the pair shows J (`dp`=0, `dm`=1).
- R2: When `reqValid` is sampled high while idle, `oe` rises at that clock edge. The pair holds J for exactly one bit period before the first sync bit.
- R3: After the lead J, the byte 8'h80 goes out first, then exactly `reqLen` payload bytes in fetch order, each least significant bit first. A `reqLen` of 1 gives a handshake packet and a `reqLen` of 0 gives a sync-only packet.
- R4: Line coding is NRZI. A 0 bit flips the pair between J (`dp`=0, `dm`=1) and K (`dp`=1, `dm`=0), and a 1 bit keeps the previous state. Both lines are never driven high together.
- R5: After six consecutive 1 bits, one extra flip is sent as a stuffed bit. The run count spans byte boundaries and clears on a 0 bit or a stuffed bit. A run that completes on the final payload bit still gets its stuffed bit before the end of the packet.
- R6: After the last bit, the pair shows SE0 (`dp`=0, `dm`=0) for two bit periods, then J for one bit period, and then `oe` falls.
- R7: Every symbol lasts exactly DIV = CLK_HZ/BIT_HZ clock cycles, and the pair changes only at bit-period boundaries. `oe` is high for exactly DIV times the number of symbols in the packet.
- R8: `byteReq` is a one-cycle pulse. The block issues exactly `reqLen` of them per packet, the first in the cycle after acceptance and each later one when a payload byte starts to shift out. The byte on `byteData` is captured in a cycle where `byteValid` is high, and the source must answer within seven bit periods.
- R9: `done` is a one-cycle pulse, raised at the same clock edge at which `oe` falls.
- R10: `reqValid` has no effect while a packet is in progress. The packet on the wire is unchanged, and no second packet follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a packet (sampled only while idle) |
| reqLen | input | LEN_W | Payload byte count after sync |
| byteValid | input | 1 | Byte source answer strobe |
| byteData | input | 8 | Payload byte from the source |
| byteReq | output | 1 | Pulse asking the source for the next byte |
| dp | output | 1 | D+ line level |
| dm | output | 1 | D- line level |
| oe | output | 1 | Drive enable for both lines |
| done | output | 1 | Pulse when the lines are released |

## Verification
Each directed packet is sampled in the middle of every bit period and compared against a symbol stream that the bench builds itself from the payload bytes. An all-zero payload flips the pair on every bit and separates toggling from holding. A payload of 0xFF bytes forces stuffed bits in the middle of bytes and across byte edges, which shows whether the run counter carries over or restarts per byte. A byte ending in six ones places a stuffed bit right before SE0, and zero-length and single-byte requests test the sync-only and handshake edges. One packet also receives a stray request mid-flight, to check that it is ignored.

// File: rtl/lsTxPkg.sv
package lsTxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BITS,
    ST_EOP_A,
    ST_EOP_B,
    ST_TAIL
  } txState_t;

  typedef enum logic [1:0] {
    LINE_J,
    LINE_DATA,
    LINE_SE0
  } lineMode_t;

  // strobes from control into the datapath
  typedef struct packed {
    logic start;
    logic emitBit;
    logic emitStuff;
  } txStrobe_t;

  localparam logic [7:0] SYNC_PATTERN = 8'h80;
  localparam logic [2:0] STUFF_RUN    = 3'd6;

endpackage

// File: rtl/lsTxPath.sv
module lsTxPath
  import lsTxPkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  lineMode_t        lineMode,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             bitTick,
  output logic             stuffDue,
  output logic             payloadDone,
  output logic             byteReq,
  output logic             dp,
  output logic             dm
);

  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  logic [CNT_W-1:0] divCnt;
  logic [7:0]       curByte;
  logic [7:0]       nextByte;
  logic [2:0]       bitIdx;
  logic [2:0]       onesRun;
  logic [LEN_W-1:0] remaining;
  logic             lineK;
  logic             curBit;

  assign curBit   = curByte[0];
  assign bitTick  = (divCnt == CNT_LAST);
  assign stuffDue = (onesRun == STUFF_RUN);

  // bit-period divider, realigned on every new packet
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strobe.start || bitTick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  // prefetch register filled by the byte source
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextByte <= '0;
    end else if (byteValid) begin
      nextByte <= byteData;
    end
  end

  // shifter, run counter, NRZI level and fetch pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curByte     <= '0;
      bitIdx      <= '0;
      onesRun     <= '0;
      remaining   <= '0;
      payloadDone <= 1'b0;
      lineK       <= 1'b0;
      byteReq     <= 1'b0;
    end else begin
      byteReq <= 1'b0;
      if (strobe.start) begin
        curByte     <= SYNC_PATTERN;
        bitIdx      <= '0;
        onesRun     <= '0;
        remaining   <= reqLen;
        payloadDone <= 1'b0;
        lineK       <= 1'b0;
        byteReq     <= (reqLen != '0);
      end else if (strobe.emitStuff) begin
        lineK   <= ~lineK;
        onesRun <= '0;
      end else if (strobe.emitBit) begin
        lineK   <= curBit ? lineK : ~lineK;
        onesRun <= curBit ? onesRun + 3'd1 : 3'd0;
        if (bitIdx == 3'd7) begin
          bitIdx <= '0;
          if (remaining != '0) begin
            curByte   <= nextByte;
            remaining <= remaining - LEN_ONE;
            byteReq   <= (remaining != LEN_ONE);
          end else begin
            payloadDone <= 1'b1;
          end
        end else begin
          bitIdx  <= bitIdx + 3'd1;
          curByte <= {1'b0, curByte[7:1]};
        end
      end
    end
  end

  always_comb begin
    unique case (lineMode)
      LINE_DATA: begin dp = lineK; dm = ~lineK; end
      LINE_SE0:  begin dp = 1'b0;  dm = 1'b0;   end
      default:   begin dp = 1'b0;  dm = 1'b1;   end
    endcase
  end

endmodule

// File: rtl/lsTxCtrl.sv
module lsTxCtrl
  import lsTxPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      bitTick,
  input  logic      stuffDue,
  input  logic      payloadDone,
  output txStrobe_t strobe,
  output lineMode_t lineMode,
  output logic      oe,
  output logic      done
);

  txState_t state, stateNext;
  logic     doneNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    doneNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.start = 1'b1;
          stateNext    = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (bitTick) begin
          strobe.emitBit = 1'b1;
          stateNext      = ST_BITS;
        end
      end
      ST_BITS: begin
        if (bitTick) begin
          if (stuffDue) begin
            strobe.emitStuff = 1'b1;
          end else if (payloadDone) begin
            stateNext = ST_EOP_A;
          end else begin
            strobe.emitBit = 1'b1;
          end
        end
      end
      ST_EOP_A: if (bitTick) stateNext = ST_EOP_B;
      ST_EOP_B: if (bitTick) stateNext = ST_TAIL;
      ST_TAIL: begin
        if (bitTick) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
    end
  end

  always_comb begin
    unique case (state)
      ST_BITS:            lineMode = LINE_DATA;
      ST_EOP_A, ST_EOP_B: lineMode = LINE_SE0;
      default:            lineMode = LINE_J;
    endcase
  end

  assign oe = (state != ST_IDLE);

endmodule

// File: rtl/lsPacketTx.sv
module lsPacketTx
  import lsTxPkg::*;
#(
  parameter int CLK_HZ = 12_000_000,
  parameter int BIT_HZ = 1_500_000,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  output logic             byteReq,
  output logic             dp,
  output logic             dm,
  output logic             oe,
  output logic             done
);

  localparam int DIV = CLK_HZ / BIT_HZ;

  txStrobe_t strobe;
  lineMode_t lineMode;
  logic      bitTick;
  logic      stuffDue;
  logic      payloadDone;

  lsTxCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .bitTick    (bitTick),
    .stuffDue   (stuffDue),
    .payloadDone(payloadDone),
    .strobe     (strobe),
    .lineMode   (lineMode),
    .oe         (oe),
    .done       (done)
  );

  lsTxPath #(.LEN_W(LEN_W), .DIV(DIV)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lineMode   (lineMode),
    .reqLen     (reqLen),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .bitTick    (bitTick),
    .stuffDue   (stuffDue),
    .payloadDone(payloadDone),
    .byteReq    (byteReq),
    .dp         (dp),
    .dm         (dm)
  );

endmodule

// File: rtl/lsPacketTxChk.sv
module lsPacketTxChk (
  input logic clk,
  input logic rstN,
  input logic oe,
  input logic dp,
  input logic dm,
  input logic done,
  input logic byteReq,
  input logic bitTick
);

  AST_NO_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    oe |-> !(dp && dm));  // R4

  AST_LEAD_IS_J: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oe) |-> (!dp && dm));  // R2

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (oe && $past(oe) && ({dp, dm} != $past({dp, dm}))) |-> $past(bitTick));  // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R9

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!oe && $past(oe)));  // R9

  AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    byteReq |=> !byteReq);  // R8

endmodule

bind lsPacketTx lsPacketTxChk uChk (
  .clk    (clk),
  .rstN   (rstN),
  .oe     (oe),
  .dp     (dp),
  .dm     (dm),
  .done   (done),
  .byteReq(byteReq),
  .bitTick(bitTick)
);

// File: tb/sim_lsPacketTx.sv
module sim_lsPacketTx;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 12_000_000 / 1_500_000;
  localparam logic [1:0] SYM_J   = 2'b01;
  localparam logic [1:0] SYM_K   = 2'b10;
  localparam logic [1:0] SYM_SE0 = 2'b00;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqLen = '0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       byteReq, dp, dm, oe, done;

  int checks = 0;
  int errors = 0;
  int fetchIdx = 0;
  int fetchCount = 0;
  int doneCount = 0;
  int oeCycles = 0;
  logic [7:0] pl [0:15];
  logic [1:0] expSym [0:255];
  int nExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsPacketTx u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .byteValid(byteValid), .byteData(byteData), .byteReq(byteReq),
    .dp(dp), .dm(dm), .oe(oe), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // byte source: answers one cycle after each fetch pulse
  initial begin
    forever begin
      @(negedge clk);
      if (byteReq) begin
        byteData  = pl[fetchIdx];
        fetchIdx++;
        fetchCount++;
        byteValid = 1'b1;
      end else begin
        byteValid = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (oe) oeCycles++;
    if (done) begin
      doneCount++;
      check(!oe, "R9", "oe at done", int'(oe), 0);
    end
  end

  // independent encoder of the expected line symbols
  task automatic buildExp(input int len);
    logic [1:0] lvl;
    int run;
    logic [7:0] b;
    lvl = SYM_J;
    run = 0;
    nExp = 0;
    expSym[nExp++] = SYM_J;
    for (int k = 0; k <= len; k++) begin
      b = (k == 0) ? 8'h80 : pl[k-1];
      for (int i = 0; i < 8; i++) begin
        if (b[i]) run++;
        else begin
          run = 0;
          lvl = (lvl == SYM_J) ? SYM_K : SYM_J;
        end
        expSym[nExp++] = lvl;
        if (run == 6) begin
          lvl = (lvl == SYM_J) ? SYM_K : SYM_J;
          expSym[nExp++] = lvl;
          run = 0;
        end
      end
    end
    expSym[nExp++] = SYM_SE0;
    expSym[nExp++] = SYM_SE0;
    expSym[nExp++] = SYM_J;
  endtask

  task automatic runPacket(input string tag, input int len, input bit poke);
    string req;
    buildExp(len);
    fetchIdx = 0;
    fetchCount = 0;
    doneCount = 0;
    oeCycles = 0;
    @(negedge clk);
    reqLen = 8'(len);
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(byteReq == (len != 0), "R8", {tag, " first fetch"}, int'(byteReq), int'(len != 0));
    repeat (BIT_CYC/2 - 1) @(negedge clk);
    for (int s = 0; s < nExp; s++) begin
      if (s == 0) req = "R2";
      else if (s >= nExp - 3) req = "R6";
      else req = tag;
      check(oe && ({dp, dm} == expSym[s]), req, $sformatf("symbol %0d {oe,dp,dm}", s),
            int'({oe, dp, dm}), int'({1'b1, expSym[s]}));
      if (poke && s == 12) begin
        reqLen = 8'd5;
        reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
        repeat (BIT_CYC - 1) @(negedge clk);
      end else begin
        repeat (BIT_CYC) @(negedge clk);
      end
    end
    check(!oe, "R6", {tag, " released after tail J"}, int'(oe), 0);
    repeat (3 * BIT_CYC) @(negedge clk);
    check(!oe, "R10", {tag, " no second packet"}, int'(oe), 0);
    check(doneCount == 1, "R9", {tag, " done pulses"}, doneCount, 1);
    check(fetchCount == len, "R8", {tag, " fetch count"}, fetchCount, len);
    check(oeCycles == nExp * BIT_CYC, "R7", {tag, " oe cycles"}, oeCycles, nExp * BIT_CYC);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(!oe && !done && !byteReq, "R1", "outputs in reset", int'({oe, done, byteReq}), 0);
    check(!dp && dm, "R1", "lines J in reset", int'({dp, dm}), int'(SYM_J));
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!oe && !done && !byteReq, "R1", "outputs after reset", int'({oe, done, byteReq}), 0);
  endtask

  task automatic testHandshake();
    pl[0] = 8'hD2;
    runPacket("R3 handshake", 1, 1'b0);
  endtask

  task automatic testZeros();
    pl[0] = 8'h00; pl[1] = 8'h00; pl[2] = 8'h00;
    runPacket("R4 zeros", 3, 1'b0);
  endtask

  task automatic testStuffSpan();
    pl[0] = 8'hC3; pl[1] = 8'hFF; pl[2] = 8'hFF; pl[3] = 8'h01; pl[4] = 8'h7E;
    runPacket("R5 span", 5, 1'b0);
  endtask

  task automatic testStuffAtEnd();
    pl[0] = 8'hFC;
    runPacket("R5 tail", 1, 1'b0);
  endtask

  task automatic testEmpty();
    runPacket("R3 empty", 0, 1'b0);
  endtask

  task automatic testBusyIgnore();
    pl[0] = 8'hA5; pl[1] = 8'h3C;
    runPacket("R10 busy", 2, 1'b1);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    testReset();
    testHandshake();
    testZeros();
    testStuffSpan();
    testStuffAtEnd();
    testEmpty();
    testBusyIgnore();
    summary();
    $finish;
  end

endmodule